// File: doc/BRIEF.md
# Receive Clock Source Generator

This block produces the receive-side bit-clock enable for a serial controller. An internal rate generator divides the system clock in three cascaded steps. The first is a fixed divide by two. The second is a programmable time-constant divide of 1 to 256. The third is a power-of-two prescale of 2^0 to 2^9. A source selector picks either the generator output or rising edges seen on an external receive-clock pin. The pin input passes through a two-flop synchronizer first.

Behind the selector sits a clock-mode divider. In asynchronous operation it divides by 1, 16, 32 or 64. In both synchronous operating modes it is forced to divide by 1. Every output is a single-cycle enable pulse in the system clock domain, not a derived clock.

The block also controls the direction of the receive-clock pin. When the pin is not used as the clock source, it is turned into an output. It then carries a square wave that flips on every generator pulse. Any configuration change restarts every counter, so no pulse ever comes from a count that was started under the old settings.

Top module: `rx_clk_gen`

## Requirements
- R1: With the internal source selected and divide-by-1 in effect, `rx_clk_en` pulses high for one cycle every 2·N·2^E system clocks. N is `cfg_tc`, except that 0 means 2^TC_W. E is `cfg_exp`.
- R2: A `cfg_exp` value above MAX_EXP behaves exactly as MAX_EXP.
- R3: With `cfg_opmode` = 0 (asynchronous), `cfg_cmode` selects the post-divide as follows: 0 gives /1, 1 gives /16, 2 gives /32 and 3 gives /64.
- R4: With `cfg_opmode` = 1 (byte-synchronous), 2 (bit-synchronous) or 3 (handled as synchronous), the post-divide is /1 whatever `cfg_cmode` holds.
- R5: With `cfg_src_ext` = 1, each rising edge of `rxc_pin_i` is counted as one source tick. A 0-to-1 change driven before clock edge k gives a pulse in the cycle after edge k+1. The internal generator then produces no pulses.
- R6: `rxc_pin_oe` is 1 when the internal source is selected and 0 when the pin is the source. It follows `cfg_src_ext` one cycle after that input changes.
- R7: With the internal source, `rxc_pin_o` starts at 0 after a configuration change and inverts in the cycle after every generator pulse. With the pin as the source, `rxc_pin_o` stays 0.
- R8: Suppose a configuration input changes before edge k. Then `rx_clk_en` stays low in that cycle, and the first pulse comes P·D cycles after edge k−1, where P is the generator period and D the post-divide. This holds wherever the old count stood.
- R9: During reset `rx_clk_en` is 0, `rxc_pin_o` is 0 and `rxc_pin_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tc | input | TC_W | Time-constant divide, 0 means 2^TC_W |
| cfg_exp | input | EXP_W | Power-of-two prescale exponent |
| cfg_src_ext | input | 1 | 1 selects the receive-clock pin as the source |
| cfg_cmode | input | 2 | Asynchronous post-divide select |
| cfg_opmode | input | 2 | 0 asynchronous, 1 byte-sync, 2 bit-sync, 3 sync |
| rxc_pin_i | input | 1 | Receive-clock pin input, asynchronous |
| rxc_pin_o | output | 1 | Receive-clock pin output level |
| rxc_pin_oe | output | 1 | Receive-clock pin output enable |
| rx_clk_en | output | 1 | One-cycle receive clock enable |

## Verification
The bench builds the block with TC_W = 3, EXP_W = 3 and MAX_EXP = 3. These values keep every period at or below 128 cycles. The whole time-constant and exponent space can therefore be swept, including the wrap of 0 to 8 and the clamping of exponents 4 to 7. Every operating-mode and clock-mode pair is also run against arithmetic period expectations, along with pin-driven edges and a reload in the middle of a count.

// File: rtl/rx_clk_pkg.sv
package rx_clk_pkg;

  typedef enum logic [1:0] {
    OPM_ASYNC = 2'd0,
    OPM_BYTE  = 2'd1,
    OPM_BIT   = 2'd2,
    OPM_SYNC3 = 2'd3
  } opmode_e;

  typedef enum logic [1:0] {
    CM_X1  = 2'd0,
    CM_X16 = 2'd1,
    CM_X32 = 2'd2,
    CM_X64 = 2'd3
  } cmode_e;

  localparam int unsigned MODE_CNT_W = 6;

  // last count value of the post-divider for a given clock mode
  function automatic logic [MODE_CNT_W-1:0] cmode_last(input cmode_e cm);
    case (cm)
      CM_X16:  cmode_last = MODE_CNT_W'(15);
      CM_X32:  cmode_last = MODE_CNT_W'(31);
      CM_X64:  cmode_last = MODE_CNT_W'(63);
      default: cmode_last = '0;
    endcase
  endfunction

endpackage

// File: rtl/rx_clk_pin_sync.sv
module rx_clk_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_tick
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;
  logic              last_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin_i};
    last_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign rise_tick = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/rx_clk_brg.sv
module rx_clk_brg #(
  parameter int unsigned TC_W    = 8,
  parameter int unsigned EXP_W   = 4,
  parameter int unsigned MAX_EXP = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic [TC_W-1:0]  tc,
  input  logic [EXP_W-1:0] exp_sel,
  output logic             tick
);

  localparam int unsigned PRE_W = (MAX_EXP > 0) ? MAX_EXP : 1;
  localparam logic [EXP_W-1:0] EXP_CAP = EXP_W'(MAX_EXP);

  logic             half_q, half_d;
  logic [TC_W-1:0]  tc_cnt_q, tc_cnt_d;
  logic [PRE_W-1:0] pre_cnt_q, pre_cnt_d;

  logic [TC_W-1:0]  tc_last;
  logic [EXP_W-1:0] exp_eff;
  logic [PRE_W:0]   pre_span;
  logic [PRE_W-1:0] pre_last;
  logic             half_tick, tc_tick, pre_wrap;

  always_comb begin
    // 0 wraps to all ones, giving the full 2^TC_W divide
    tc_last   = tc - TC_W'(1);
    exp_eff   = (exp_sel > EXP_CAP) ? EXP_CAP : exp_sel;
    pre_span  = ({{PRE_W{1'b0}}, 1'b1} << exp_eff) - (PRE_W+1)'(1);
    pre_last  = pre_span[PRE_W-1:0];
    half_tick = half_q;
    tc_tick   = half_tick & (tc_cnt_q == tc_last);
    pre_wrap  = pre_cnt_q == pre_last;
  end

  always_comb begin
    half_d    = half_q;
    tc_cnt_d  = tc_cnt_q;
    pre_cnt_d = pre_cnt_q;
    if (reload) begin
      half_d    = 1'b0;
      tc_cnt_d  = '0;
      pre_cnt_d = '0;
    end else begin
      half_d = ~half_q;
      if (half_tick) begin
        tc_cnt_d = tc_tick ? '0 : tc_cnt_q + TC_W'(1);
      end
      if (tc_tick) begin
        pre_cnt_d = pre_wrap ? '0 : pre_cnt_q + PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q    <= 1'b0;
      tc_cnt_q  <= '0;
      pre_cnt_q <= '0;
    end else begin
      half_q    <= half_d;
      tc_cnt_q  <= tc_cnt_d;
      pre_cnt_q <= pre_cnt_d;
    end
  end

  assign tick = tc_tick & pre_wrap & ~reload;

endmodule

// File: rtl/rx_clk_mode_div.sv
module rx_clk_mode_div
  import rx_clk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     reload,
  input  logic     src_tick,
  input  logic     sync_mode,
  input  cmode_e   cmode,
  output logic     en
);

  logic [MODE_CNT_W-1:0] cnt_q, cnt_d;
  logic [MODE_CNT_W-1:0] last;
  logic                  at_last;

  always_comb begin
    last    = sync_mode ? '0 : cmode_last(cmode);
    at_last = cnt_q == last;
    cnt_d   = cnt_q;
    if (reload) begin
      cnt_d = '0;
    end else if (src_tick) begin
      cnt_d = at_last ? '0 : cnt_q + MODE_CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign en = src_tick & at_last & ~reload;

endmodule

// File: rtl/rx_clk_gen.sv
module rx_clk_gen
  import rx_clk_pkg::*;
#(
  parameter int unsigned TC_W    = 8,
  parameter int unsigned EXP_W   = 4,
  parameter int unsigned MAX_EXP = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TC_W-1:0]  cfg_tc,
  input  logic [EXP_W-1:0] cfg_exp,
  input  logic             cfg_src_ext,
  input  logic [1:0]       cfg_cmode,
  input  logic [1:0]       cfg_opmode,
  input  logic             rxc_pin_i,
  output logic             rxc_pin_o,
  output logic             rxc_pin_oe,
  output logic             rx_clk_en
);

  localparam int unsigned CFG_W = TC_W + EXP_W + 5;

  logic [CFG_W-1:0] cfg_in, cfg_q;
  logic [TC_W-1:0]  tc_q;
  logic [EXP_W-1:0] exp_q;
  logic             src_ext_q;
  cmode_e           cmode_q;
  opmode_e          opmode_q;
  logic             reload;

  logic brg_tick, ext_tick, src_tick, sync_mode;
  logic tgl_q, tgl_d;

  assign cfg_in = {cfg_tc, cfg_exp, cfg_src_ext, cfg_cmode, cfg_opmode};
  assign reload = cfg_in != cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (reload) begin
      cfg_q <= cfg_in;
    end
  end

  always_comb begin
    tc_q      = cfg_q[CFG_W-1 -: TC_W];
    exp_q     = cfg_q[EXP_W+4 : 5];
    src_ext_q = cfg_q[4];
    cmode_q   = cmode_e'(cfg_q[3:2]);
    opmode_q  = opmode_e'(cfg_q[1:0]);
    sync_mode = opmode_q != OPM_ASYNC;
  end

  rx_clk_brg #(
    .TC_W    (TC_W),
    .EXP_W   (EXP_W),
    .MAX_EXP (MAX_EXP)
  ) u_brg (
    .clk     (clk),
    .rst_n   (rst_n),
    .reload  (reload),
    .tc      (tc_q),
    .exp_sel (exp_q),
    .tick    (brg_tick)
  );

  rx_clk_pin_sync #(
    .STAGES (2)
  ) u_pin_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_i     (rxc_pin_i),
    .rise_tick (ext_tick)
  );

  assign src_tick = src_ext_q ? ext_tick : brg_tick;

  rx_clk_mode_div u_mode_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .reload    (reload),
    .src_tick  (src_tick),
    .sync_mode (sync_mode),
    .cmode     (cmode_q),
    .en        (rx_clk_en)
  );

  // pin output square wave, flips on each generator tick
  always_comb begin
    tgl_d = tgl_q;
    if (reload) begin
      tgl_d = 1'b0;
    end else if (!src_ext_q && brg_tick) begin
      tgl_d = ~tgl_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_q <= 1'b0;
    end else begin
      tgl_q <= tgl_d;
    end
  end

  assign rxc_pin_o  = tgl_q & ~src_ext_q;
  assign rxc_pin_oe = ~src_ext_q;

endmodule

// File: rtl/rx_clk_gen_chk.sv
module rx_clk_gen_chk #(
  parameter int unsigned TC_W  = 8,
  parameter int unsigned EXP_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [TC_W-1:0]  cfg_tc,
  input logic [EXP_W-1:0] cfg_exp,
  input logic             cfg_src_ext,
  input logic [1:0]       cfg_cmode,
  input logic [1:0]       cfg_opmode,
  input logic             rxc_pin_i,
  input logic             rxc_pin_o,
  input logic             rxc_pin_oe,
  input logic             rx_clk_en
);

  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
    end else if (age_q != 2'd3) begin
      age_q <= age_q + 2'd1;
    end
  end

  // R1
  en_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clk_en |=> !rx_clk_en);

  // R6
  oe_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0) |-> (rxc_pin_oe == !$past(cfg_src_ext)));

  // R7
  ext_pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rxc_pin_oe |-> !rxc_pin_o);

  // R8
  reload_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((age_q != 2'd0) &&
     ({cfg_tc, cfg_exp, cfg_src_ext, cfg_cmode, cfg_opmode} !=
      $past({cfg_tc, cfg_exp, cfg_src_ext, cfg_cmode, cfg_opmode})))
    |-> !rx_clk_en);

  // R5
  ext_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((age_q == 2'd3) && cfg_src_ext && $past(cfg_src_ext) && rx_clk_en)
    |-> ($past(rxc_pin_i, 2) && !$past(rxc_pin_i, 3)));

endmodule

bind rx_clk_gen rx_clk_gen_chk #(
  .TC_W  (TC_W),
  .EXP_W (EXP_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_tc      (cfg_tc),
  .cfg_exp     (cfg_exp),
  .cfg_src_ext (cfg_src_ext),
  .cfg_cmode   (cfg_cmode),
  .cfg_opmode  (cfg_opmode),
  .rxc_pin_i   (rxc_pin_i),
  .rxc_pin_o   (rxc_pin_o),
  .rxc_pin_oe  (rxc_pin_oe),
  .rx_clk_en   (rx_clk_en)
);

// File: tb/rx_clk_gen_tb.sv
module rx_clk_gen_tb;

  localparam int TC_W    = 3;
  localparam int EXP_W   = 3;
  localparam int MAX_EXP = 3;

  logic             clk;
  logic             rst_n;
  logic [TC_W-1:0]  cfg_tc;
  logic [EXP_W-1:0] cfg_exp;
  logic             cfg_src_ext;
  logic [1:0]       cfg_cmode;
  logic [1:0]       cfg_opmode;
  logic             rxc_pin_i;
  logic             rxc_pin_o;
  logic             rxc_pin_oe;
  logic             rx_clk_en;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  rx_clk_gen #(
    .TC_W    (TC_W),
    .EXP_W   (EXP_W),
    .MAX_EXP (MAX_EXP)
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_tc      (cfg_tc),
    .cfg_exp     (cfg_exp),
    .cfg_src_ext (cfg_src_ext),
    .cfg_cmode   (cfg_cmode),
    .cfg_opmode  (cfg_opmode),
    .rxc_pin_i   (rxc_pin_i),
    .rxc_pin_o   (rxc_pin_o),
    .rxc_pin_oe  (rxc_pin_oe),
    .rx_clk_en   (rx_clk_en)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
        finish_up();
      end
    end
  end

  function automatic int post_div(input int op, input int cm);
    if (op != 0) return 1;
    case (cm)
      1: return 16;
      2: return 32;
      3: return 64;
      default: return 1;
    endcase
  endfunction

  function automatic int gen_period(input int tc, input int e);
    int n;
    int ee;
    n  = (tc == 0) ? (1 << TC_W) : tc;
    ee = (e > MAX_EXP) ? MAX_EXP : e;
    return 2 * n * (1 << ee);
  endfunction

  // apply an internal-source config and measure npulse pulse spacings
  task automatic run_int(input string req, input int tc, input int e,
                         input int op, input int cm, input int npulse);
    int per;
    int k;
    int got;
    int lvl;
    int pin_bad;
    per = gen_period(tc, e) * post_div(op, cm);
    @(negedge clk);
    cfg_tc      = TC_W'(tc);
    cfg_exp     = EXP_W'(e);
    cfg_src_ext = 1'b0;
    cfg_cmode   = 2'(cm);
    cfg_opmode  = 2'(op);
    lvl = 0;
    pin_bad = 0;
    for (int p = 0; p < npulse; p++) begin
      k = 0;
      got = 0;
      while (!got && k < per + 2) begin
        @(negedge clk);
        k++;
        if (post_div(op, cm) == 1 && int'(rxc_pin_o) != lvl) pin_bad++;
        if (rx_clk_en) begin
          got = 1;
          lvl = 1 - lvl;
        end
      end
      check(req, $sformatf("spacing tc=%0d e=%0d op=%0d cm=%0d n=%0d", tc, e, op, cm, p),
            k, per);
    end
    if (post_div(op, cm) == 1)
      check("R7", $sformatf("pin wave mismatches tc=%0d e=%0d", tc, e), pin_bad, 0);
  endtask

  // pin as the source: one rising edge per 8-cycle frame
  task automatic run_ext(input int op, input int cm, input int nedge);
    int d;
    int miss;
    int pulses;
    d = post_div(op, cm);
    @(negedge clk);
    cfg_src_ext = 1'b1;
    cfg_tc      = TC_W'(1);
    cfg_exp     = '0;
    cfg_cmode   = 2'(cm);
    cfg_opmode  = 2'(op);
    rxc_pin_i   = 1'b0;
    miss = 0;
    pulses = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      pulses += int'(rx_clk_en);
    end
    check("R5", "no pulse from generator with pin source", pulses, 0);
    check("R6", "oe with pin source", int'(rxc_pin_oe), 0);
    check("R7", "pin out with pin source", int'(rxc_pin_o), 0);
    for (int ed = 0; ed < nedge; ed++) begin
      rxc_pin_i = 1'b1;
      for (int c = 1; c <= 8; c++) begin
        @(negedge clk);
        if (int'(rx_clk_en) != (((c == 2) && ((ed + 1) % d == 0)) ? 1 : 0)) miss++;
        if (c == 4) rxc_pin_i = 1'b0;
      end
    end
    check("R5", $sformatf("pin edge pulses op=%0d cm=%0d", op, cm), miss, 0);
  endtask

  initial begin
    rst_n       = 1'b0;
    cfg_tc      = 3'd5;
    cfg_exp     = 3'd2;
    cfg_src_ext = 1'b1;
    cfg_cmode   = 2'd1;
    cfg_opmode  = 2'd0;
    rxc_pin_i   = 1'b0;
    repeat (3) @(negedge clk);
    check("R9", "reset en", int'(rx_clk_en), 0);
    check("R9", "reset pin out", int'(rxc_pin_o), 0);
    check("R9", "reset oe", int'(rxc_pin_oe), 1);
    cfg_src_ext = 1'b0;
    cfg_cmode   = 2'd0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R6", "oe with internal source", int'(rxc_pin_oe), 1);

    // R1 / R2: full sweep of time constant and exponent
    for (int t = 0; t < (1 << TC_W); t++) begin
      for (int e = 0; e < (1 << EXP_W); e++) begin
        run_int((e > MAX_EXP) ? "R2" : "R1", t, e, 0, 0, 2);
      end
    end

    // R3: asynchronous clock modes
    for (int cm = 1; cm < 4; cm++) begin
      run_int("R3", 1, 0, 0, cm, 2);
      run_int("R3", 3, 1, 0, cm, 1);
    end

    // R4: synchronous modes ignore the clock-mode field
    for (int op = 1; op < 4; op++) begin
      for (int cm = 0; cm < 4; cm++) begin
        run_int("R4", 2, 1, op, cm, 3);
      end
    end

    // R8: reload in the middle of a long count
    @(negedge clk);
    cfg_tc = '0; cfg_exp = 3'd3; cfg_opmode = 2'd0; cfg_cmode = 2'd0;
    repeat (50) @(negedge clk);
    run_int("R8", 3, 0, 0, 0, 2);
    @(negedge clk);
    cfg_tc = 3'd7; cfg_exp = 3'd2;
    repeat (37) @(negedge clk);
    run_int("R8", 1, 1, 1, 2, 2);

    // R5 / R6 / R7: pin as the source
    run_ext(1, 0, 4);
    run_ext(2, 3, 3);
    run_ext(0, 1, 32);

    // back to internal source: direction returns
    @(negedge clk);
    cfg_src_ext = 1'b0;
    @(negedge clk);
    check("R6", "oe after return to internal", int'(rxc_pin_oe), 1);
    run_int("R1", 1, 0, 0, 0, 4);

    finish_up();
  end

endmodule